// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block turns single-byte read and write requests from a synchronous valid/ready interface into correctly ordered pin activity on an 8K x 8 asynchronous static RAM. It owns the memory's address bus, its three active-low strobes (chip select, output enable, write strobe) and a bidirectional byte bus. The byte bus is split into an outgoing value, an incoming value and a drive-enable signal that a pad ring combines.

Each accepted request runs the same fixed sequence. A setup cycle places the address on the bus with every strobe inactive. An active phase follows: a read lowers chip select and output enable, and a write lowers chip select and the write strobe while driving the byte. A recovery phase then holds every strobe inactive before the next request may be accepted. Three compile-time cycle counts set the read access time, the write pulse width and the recovery gap. Read data is returned together with a one-cycle completion strobe. Writes raise the same strobe.

Top module: `sram_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of a transfer, leaves ready high, chip select, output enable and write strobe all high (1), and the byte bus not driven (drive-enable 0) on the next cycle.
- R2: Ready is high only when the controller is idle. A request is accepted on a clock edge where valid and ready are both high. Ready is low from the cycle after acceptance until recovery ends. A valid pulse presented while ready is low is ignored and leaves the memory contents unchanged.
- R3: A read presents the address for one setup cycle with all strobes high. It then holds chip select and output enable low, with the write strobe high, for exactly ACCESS_CYC cycles.
- R4: The incoming byte is sampled at the clock edge that ends the last access cycle. The completion strobe is high for exactly one cycle, ACCESS_CYC+1 cycles after the setup cycle, and carries that byte on the response data output.
- R5: A write presents the address for one setup cycle with all strobes high. It then holds chip select and the write strobe low for exactly WPULSE_CYC cycles. Output enable stays high throughout a write.
- R6: Drive-enable is high only while the write strobe is low. While it is high, the outgoing byte equals the accepted write data. The completion strobe follows the write pulse by one cycle.
- R7: The memory address does not change while chip select is low, and it equals the accepted request address.
- R8: After each active phase, all strobes stay high for RECOV_CYC cycles before ready rises again. Ready returns ACCESS_CYC+RECOV_CYC+2 cycles after acceptance for a read, and WPULSE_CYC+RECOV_CYC+2 cycles after acceptance for a write.
- R9: A byte written to any address is returned by a later read of that address. Other writes to that address would change it; a rejected request does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request may be accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Write byte |
| doneStb | output | 1 | One-cycle completion strobe |
| rspData | output | DATA_W | Read byte, valid with doneStb on reads |
| memAddr | output | ADDR_W | Memory address bus |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| memDout | output | DATA_W | Byte driven toward the memory |
| memDoe | output | 1 | Drive enable for memDout |
| memDin | input | DATA_W | Byte returned by the memory |

## Verification
The bench samples at the falling edge and treats the first falling edge after acceptance as the setup cycle, index 0. On that basis, the completion strobe is due at index ACCESS_CYC+1 for a read (WPULSE_CYC+1 for a write), and ready at that index plus RECOV_CYC; each transfer's strobe counts are tallied over the same window. The memory model returns the inverted byte until output enable has been low for ACCESS_CYC cycles, so sampling even one cycle early shows up as a data mismatch. Full write-then-read sweeps cover every address of a 9-bit configuration in ascending and descending order. Requests injected while the controller is busy must leave a neighbouring location unchanged.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_WRITE,
    ST_RECOV
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic loadReq;    // capture request address and write byte
    logic captureRd;  // sample incoming byte
    logic driveData;  // registered bus drive enable
  } seqStrobe_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int ACCESS_CYC = 2,
  parameter int WPULSE_CYC = 2,
  parameter int RECOV_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       doneStb,
  output logic       memCeN,
  output logic       memOeN,
  output logic       memWeN,
  output seqStrobe_t strobe
);

  localparam int MAX_CYC = maxOf3(ACCESS_CYC, WPULSE_CYC, RECOV_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WPULSE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(RECOV_CYC - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             isWrite;
  logic             loadReq, captureRd;
  logic             ceQ, oeQ, weQ, driveQ, doneQ, readyQ;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    loadReq   = 1'b0;
    captureRd = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext = ST_SETUP;
          loadReq   = 1'b1;
        end
      end
      ST_SETUP: begin
        if (isWrite) begin
          stateNext = ST_WRITE;
          cntNext   = WR_LOAD;
        end else begin
          stateNext = ST_READ;
          cntNext   = ACC_LOAD;
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          stateNext = ST_RECOV;
          cntNext   = REC_LOAD;
          captureRd = 1'b1;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt == '0) begin
          stateNext = ST_RECOV;
          cntNext   = REC_LOAD;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // pin strobes registered from the next state: glitch-free at the pads
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      ceQ     <= 1'b1;
      oeQ     <= 1'b1;
      weQ     <= 1'b1;
      driveQ  <= 1'b0;
      doneQ   <= 1'b0;
      readyQ  <= 1'b1;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      if (loadReq) isWrite <= reqWrite;
      ceQ    <= !((stateNext == ST_READ) || (stateNext == ST_WRITE));
      oeQ    <= (stateNext != ST_READ);
      weQ    <= (stateNext != ST_WRITE);
      driveQ <= (stateNext == ST_WRITE);
      doneQ  <= ((state == ST_READ) || (state == ST_WRITE)) && (stateNext == ST_RECOV);
      readyQ <= (stateNext == ST_IDLE);
    end
  end

  assign reqReady         = readyQ;
  assign doneStb          = doneQ;
  assign memCeN           = ceQ;
  assign memOeN           = oeQ;
  assign memWeN           = weQ;
  assign strobe.loadReq   = loadReq && readyQ;
  assign strobe.captureRd = captureRd;
  assign strobe.driveData = driveQ;

  // cycles the write strobe has been high, saturating at the recovery count
  logic [CNT_W-1:0] weHighCnt;
  always_ff @(posedge clk) begin
    if (rst)                         weHighCnt <= CNT_W'(RECOV_CYC);
    else if (!weQ)                   weHighCnt <= '0;
    else if (int'(weHighCnt) < RECOV_CYC) weHighCnt <= weHighCnt + 1'b1;
  end

  // R8
  recovery_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(memCeN) |-> int'($past(weHighCnt)) >= RECOV_CYC);

  // R5
  no_oe_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (memOeN && !memCeN));

  // R3
  read_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (!memCeN && memWeN));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    doneStb |=> !doneStb);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memCeN && memOeN && memWeN));

endmodule

// File: rtl/sram_seq_dp.sv
module sram_seq_dp
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.captureRd) rdataQ <= memDin;
    end
  end

  assign memAddr = addrQ;
  assign memDout = wdataQ;
  assign memDoe  = strobe.driveData;
  assign rspData = rdataQ;

  // R7
  no_load_while_drive_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.driveData |-> !strobe.loadReq);

  // R6
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memDoe && $past(memDoe)) |-> $stable(memDout));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int ACCESS_CYC = 2,
  parameter int WPULSE_CYC = 2,
  parameter int RECOV_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              doneStb,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  input  logic [DATA_W-1:0] memDin
);

  seqStrobe_t strobe;

  sram_seq_fsm #(
    .ACCESS_CYC(ACCESS_CYC),
    .WPULSE_CYC(WPULSE_CYC),
    .RECOV_CYC (RECOV_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .doneStb (doneStb),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .strobe  (strobe)
  );

  sram_seq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDin  (memDin),
    .memAddr (memAddr),
    .memDout (memDout),
    .memDoe  (memDoe),
    .rspData (rspData)
  );

  // R6
  drive_in_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    memDoe |-> (!memWeN && !memCeN));

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;

  localparam int AW    = 9;
  localparam int DW    = 8;
  localparam int NA    = 3;
  localparam int NW    = 2;
  localparam int NR    = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          doneStb;
  logic [DW-1:0] rspData;
  logic [AW-1:0] memAddr;
  logic          memCeN, memOeN, memWeN, memDoe;
  logic [DW-1:0] memDout, memDin;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sram_seq_ctrl #(
    .ADDR_W(AW), .DATA_W(DW),
    .ACCESS_CYC(NA), .WPULSE_CYC(NW), .RECOV_CYC(NR)
  ) uut (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .doneStb(doneStb), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memDout(memDout), .memDoe(memDoe), .memDin(memDin)
  );

  // memory model: byte is only valid once output enable has been low NA cycles
  logic [DW-1:0] mem [DEPTH];
  int accCnt = 0;
  always @(posedge clk) begin
    if (!memCeN && !memWeN && memDoe) mem[memAddr] <= memDout;
    if (!memCeN && !memOeN) accCnt <= accCnt + 1;
    else                    accCnt <= 0;
  end
  assign memDin = (!memCeN && !memOeN && memWeN && accCnt >= NA - 1) ?
                  mem[memAddr] : ~mem[memAddr];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] patA(input int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction

  function automatic logic [DW-1:0] patB(input int a);
    return DW'(((a * 91) ^ 8'hA5) & 8'hFF);
  endfunction

  logic [DW-1:0] lastRd;

  // one transfer; intr injects a one-cycle write request while busy
  task automatic runOp(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit intr);
    int doneAt, readyAt, doneCnt, weLow, oeLow, ceLow, busBad, addrBad, oeInWr, rdyEarly;
    int act;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    doneAt = -1; readyAt = -1; doneCnt = 0; weLow = 0; oeLow = 0; ceLow = 0;
    busBad = 0; addrBad = 0; oeInWr = 0; rdyEarly = 0;
    act = wr ? NW : NA;
    for (int i = 0; i < 40 && readyAt < 0; i++) begin
      if (i > 0) @(negedge clk);
      if (intr && i == 1) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a ^ AW'(1); reqWdata = ~d;
      end
      if (intr && i == 2) reqValid = 1'b0;
      if (!memWeN) weLow++;
      if (!memOeN) oeLow++;
      if (!memCeN) ceLow++;
      if (wr && !memOeN) oeInWr++;
      if (memDoe && (!wr || memWeN || memDout !== d)) busBad++;
      if (!memCeN && memAddr !== a) addrBad++;
      if (doneStb) begin
        doneCnt++;
        if (doneAt < 0) begin doneAt = i; lastRd = rspData; end
      end
      if (reqReady) readyAt = i;
    end
    check(doneAt == act + 1, wr ? "R6 write done timing" : "R4 read done timing", doneAt, act + 1);
    check(doneCnt == 1, "R4 done width", doneCnt, 1);
    check(readyAt == act + NR + 1, "R8 ready return", readyAt, act + NR + 1);
    check(ceLow == act, "R3/R5 chip select width", ceLow, act);
    if (wr) begin
      check(weLow == NW, "R5 write strobe width", weLow, NW);
      check(oeInWr == 0, "R5 output enable in write", oeInWr, 0);
    end else begin
      check(oeLow == NA, "R3 output enable width", oeLow, NA);
      check(weLow == 0, "R3 write strobe in read", weLow, 0);
    end
    check(busBad == 0, "R6 bus drive", busBad, 0);
    check(addrBad == 0, "R7 address hold", addrBad, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(reqReady == 1'b1, "R1 ready after reset", int'(reqReady), 1);
    check({memCeN, memOeN, memWeN} == 3'b111, "R1 strobes after reset",
          int'({memCeN, memOeN, memWeN}), 7);
    check(memDoe == 1'b0, "R1 bus released after reset", int'(memDoe), 0);

    // R9 ascending write then read sweep
    for (int a = 0; a < DEPTH; a++) runOp(1'b1, AW'(a), patA(a), 1'b0);
    for (int a = 0; a < DEPTH; a++) begin
      runOp(1'b0, AW'(a), '0, 1'b0);
      check(lastRd == patA(a), "R9 readback ascending", int'(lastRd), int'(patA(a)));
    end

    // R9 descending overwrite, with R2 rejected requests at some addresses
    for (int a = DEPTH - 1; a >= 0; a--) runOp(1'b1, AW'(a), patB(a), (a % 64) == 2);
    for (int a = DEPTH - 1; a >= 0; a--) begin
      runOp(1'b0, AW'(a), '0, 1'b0);
      check(lastRd == patB(a), "R9 readback descending", int'(lastRd), int'(patB(a)));
    end
    // R2 explicit: rejected request targeted address 3 with inverted data
    runOp(1'b0, AW'(3), '0, 1'b0);
    check(lastRd == patB(3), "R2 busy request ignored", int'(lastRd), int'(patB(3)));

    // R1 reset in the middle of a write pulse
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(7); reqWdata = 8'h3C;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check(memWeN == 1'b0, "R5 pulse active before reset", int'(memWeN), 0);
    rst = 1'b1;
    @(negedge clk);
    check({memCeN, memOeN, memWeN} == 3'b111, "R1 strobes after mid-write reset",
          int'({memCeN, memOeN, memWeN}), 7);
    check(memDoe == 1'b0, "R1 bus released after mid-write reset", int'(memDoe), 0);
    check(reqReady == 1'b1, "R1 ready after mid-write reset", int'(reqReady), 1);
    rst = 1'b0;
    @(negedge clk);
    runOp(1'b0, AW'(9), '0, 1'b0);
    check(lastRd == patB(9), "R9 read after reset", int'(lastRd), int'(patB(9)));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule